// File: doc/BRIEF.md
# Cache flush and init pulse sequencer

This block turns a falling edge on a flush-cache request into a timed pair of open-drain flush pulses, one toward the processor and one toward the firmware hub. Inside the same sequence it also places a delayed init pulse on an open-drain init output. A sequence starts only when the address-20 mask level is high at the moment of the edge. When no sequence is running, the init output simply mirrors the init input. Each open-drain output is modelled as a drive-low enable: 1 pulls the line low, and 0 leaves it at high impedance.

All timing is counted in clock cycles. The flush window lasts `FLUSH_CYC` cycles. The init pulse lasts `2*INIT_HALF_CYC` cycles and begins `FLUSH_CYC-INIT_HALF_CYC` cycles into the sequence, so it straddles the end of the flush window. The init level is captured when the sequence starts. If that level is low, the init output is held low at first, then released for `INIT_GAP_CYC` cycles, and then pulsed. An optional synchroniser chain of `SYNC_STAGES` flops can be placed in front of the edge detector for an asynchronous request.

Top module: `fis_flush_init_seq`

## Requirements
- R1: Synchronous reset (`rst_i` high) releases all three drive enables to 0 and clears the edge detector. A low request seen at the first clock edges after reset starts no sequence, even if the request was high while reset was asserted.
- R2: With `SYNC_STAGES=0`, consider a clock edge at which the request is low, the request was high at the previous edge, the mask is 1 and no sequence is running. From the following cycle both flush enables are 1 for exactly `FLUSH_CYC` cycles (sequence cycles 0 to `FLUSH_CYC-1`), and then both return to 0.
- R3: In a running sequence, the init enable is 1 during sequence cycles `FLUSH_CYC-INIT_HALF_CYC` to `FLUSH_CYC+INIT_HALF_CYC-1`, which is `2*INIT_HALF_CYC` cycles. The sequence then ends.
- R4: If the init input was 0 at the starting edge, the init enable is also 1 during sequence cycles 0 to `FLUSH_CYC-INIT_HALF_CYC-INIT_GAP_CYC-1`. It is 0 for the `INIT_GAP_CYC` cycles just before the delayed pulse.
- R5: If the init input was 1 at the starting edge, the init enable is 0 until the delayed pulse. While a sequence runs, changes on the init input have no effect on the init enable.
- R6: When no sequence is running and reset is low, both flush enables are 0 and the init enable equals the inverse of the init input.
- R7: A falling edge of the request while the mask is 0 starts nothing: the flush enables stay 0 and the init enable keeps mirroring the init input.
- R8: A falling edge of the request that arrives while a sequence runs is ignored. The sequence keeps its timing and does not restart.
- R9: From the cycle after the last sequence cycle, the init enable again mirrors the init input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mask_i | input | 1 | Address-20 mask level; 1 lets a falling request start a sequence |
| flush_req_i | input | 1 | Flush-cache request; a sequence starts on its falling edge |
| init_i | input | 1 | Init input level, 0 = asserted |
| flush_cpu_drv_o | output | 1 | Drive-low enable for the processor flush line |
| flush_hub_drv_o | output | 1 | Drive-low enable for the firmware-hub flush line |
| init_drv_o | output | 1 | Drive-low enable for the init line |

## Verification
The assertions assume the request, the mask and the init input are steady across each clock edge and change only between edges. They also assume the reset is held for at least one edge before anything is checked. The bench therefore changes every input either at the falling clock edge or shortly after a rising edge, and it starts with several reset cycles. The sweep covers every combination of mask level, captured init level, init toggling during the sequence and a second request edge during the sequence. It runs on a small timing configuration, so that every window boundary is visited and predicted arithmetically from the cycle index.

// File: rtl/fis_pkg.sv
package fis_pkg;

   // drive-low enables for the three open-drain lines
   typedef struct packed {
      logic flush_cpu;
      logic flush_hub;
      logic init;
   } fis_drive_t;

   // bits needed to count 0 .. n-1 (at least one)
   function automatic int unsigned cnt_bits(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/fis_edge_detect.sv
module fis_edge_detect #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic level_i,
   output logic fall_o
);

   localparam int unsigned VW = SYNC_STAGES + 1;

   logic       lvl_s;
   logic       prev_q;
   logic [VW-1:0] valid_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl_s = level_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) chain_q <= '1;
            else       chain_q <= {chain_q[SYNC_STAGES-2+1-1:0], level_i} ;
         end
         assign lvl_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   // valid fills with ones after reset; edges count only once the chain
   // and the previous-value flop both hold post-reset samples
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         valid_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         valid_q <= {valid_q[VW-2+1-1:0], 1'b1} ;
         prev_q  <= lvl_s;
      end
   end

   assign fall_o = valid_q[VW-1] & prev_q & ~lvl_s;

endmodule

// File: rtl/fis_seq_timer.sv
module fis_seq_timer #(
   parameter int unsigned FLUSH_CYC     = 16,
   parameter int unsigned INIT_HALF_CYC = 4,
   parameter int unsigned INIT_GAP_CYC  = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic start_i,
   input  logic init_lvl_i,
   output logic busy_o,
   output logic flush_win_o,
   output logic init_win_o
);

   import fis_pkg::*;

   localparam int unsigned SEQ_LEN = FLUSH_CYC + INIT_HALF_CYC;
   localparam int unsigned CW      = cnt_bits(SEQ_LEN);
   localparam logic [CW-1:0] LAST_C     = CW'(SEQ_LEN - 1);
   localparam logic [CW-1:0] FL_END_C   = CW'(FLUSH_CYC);
   localparam logic [CW-1:0] PULSE_ST_C = CW'(FLUSH_CYC - INIT_HALF_CYC);
   localparam logic [CW-1:0] LEAD_END_C = CW'(FLUSH_CYC - INIT_HALF_CYC - INIT_GAP_CYC);

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          cap_low_q;
   logic          lead_win;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         busy_q    <= 1'b0;
         cnt_q     <= '0;
         cap_low_q <= 1'b0;
      end else if (start_i && !busy_q) begin
         busy_q    <= 1'b1;
         cnt_q     <= '0;
         cap_low_q <= ~init_lvl_i;
      end else if (busy_q) begin
         if (cnt_q == LAST_C) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   generate
      if (INIT_GAP_CYC == 0) begin : g_no_gap
         assign lead_win = cap_low_q;
      end else begin : g_gap
         assign lead_win = cap_low_q && (cnt_q < LEAD_END_C);
      end
   endgenerate

   assign busy_o      = busy_q;
   assign flush_win_o = busy_q && (cnt_q < FL_END_C);
   assign init_win_o  = busy_q && ((cnt_q >= PULSE_ST_C) || lead_win);

endmodule

// File: rtl/fis_out_drive.sv
module fis_out_drive (
   input  logic               rst_i,
   input  logic               busy_i,
   input  logic               flush_win_i,
   input  logic               init_win_i,
   input  logic               init_i,
   output fis_pkg::fis_drive_t drv_o
);

   always_comb begin
      drv_o = '0;
      if (!rst_i) begin
         drv_o.flush_cpu = flush_win_i;
         drv_o.flush_hub = flush_win_i;
         drv_o.init      = busy_i ? init_win_i : ~init_i;
      end
   end

endmodule

// File: rtl/fis_flush_init_seq.sv
module fis_flush_init_seq #(
   parameter int unsigned FLUSH_CYC     = 16,
   parameter int unsigned INIT_HALF_CYC = 4,
   parameter int unsigned INIT_GAP_CYC  = 2,
   parameter int unsigned SYNC_STAGES   = 0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic mask_i,
   input  logic flush_req_i,
   input  logic init_i,
   output logic flush_cpu_drv_o,
   output logic flush_hub_drv_o,
   output logic init_drv_o
);

   generate
      if (INIT_HALF_CYC == 0 || INIT_HALF_CYC >= FLUSH_CYC) begin : g_bad_half
         $error("INIT_HALF_CYC must be nonzero and below FLUSH_CYC");
      end
      if (INIT_GAP_CYC >= FLUSH_CYC - INIT_HALF_CYC) begin : g_bad_gap
         $error("INIT_GAP_CYC must be below FLUSH_CYC-INIT_HALF_CYC");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic req_fall;
   logic trig;
   logic seq_busy;
   logic flush_win;
   logic init_win;
   fis_pkg::fis_drive_t drv;

   fis_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .level_i(flush_req_i),
      .fall_o (req_fall)
   );

   assign trig = req_fall & mask_i & ~seq_busy;

   fis_seq_timer #(
      .FLUSH_CYC    (FLUSH_CYC),
      .INIT_HALF_CYC(INIT_HALF_CYC),
      .INIT_GAP_CYC (INIT_GAP_CYC)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .start_i    (trig),
      .init_lvl_i (init_i),
      .busy_o     (seq_busy),
      .flush_win_o(flush_win),
      .init_win_o (init_win)
   );

   fis_out_drive u_drive (
      .rst_i      (rst_i),
      .busy_i     (seq_busy),
      .flush_win_i(flush_win),
      .init_win_i (init_win),
      .init_i     (init_i),
      .drv_o      (drv)
   );

   assign flush_cpu_drv_o = drv.flush_cpu;
   assign flush_hub_drv_o = drv.flush_hub;
   assign init_drv_o      = drv.init;

endmodule

// File: rtl/fis_flush_init_seq_chk.sv
module fis_flush_init_seq_chk #(
   parameter int unsigned FLUSH_CYC = 16
) (
   input logic clk_i,
   input logic rst_i,
   input logic mask_i,
   input logic init_i,
   input logic flush_cpu_drv_o,
   input logic flush_hub_drv_o,
   input logic init_drv_o,
   input logic trig,
   input logic seq_busy
);

   int unsigned run_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)                run_q <= 0;
      else if (flush_cpu_drv_o) run_q <= run_q + 1;
      else                      run_q <= 0;
   end

   // R1: the cycle after a reset edge has no flush drive
   p_reset_release_r1: assert property (@(posedge clk_i)
      rst_i |=> (!flush_cpu_drv_o && !flush_hub_drv_o));

   // R2: an accepted trigger drives both flush lines next cycle
   p_trig_flush_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      trig |=> (flush_cpu_drv_o && flush_hub_drv_o));

   // R2: a flush pulse ends after exactly FLUSH_CYC cycles
   p_flush_len_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      ($fell(flush_cpu_drv_o) && !$past(rst_i)) |-> (run_q == FLUSH_CYC));

   // R6: idle means plain init passthrough and no flush
   p_idle_pass_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      !seq_busy |-> (init_drv_o == !init_i && !flush_hub_drv_o));

   // R7: with mask low no new sequence begins
   p_mask_block_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (!mask_i && !seq_busy) |=> !seq_busy);

   // R8: a flush pulse never restarts inside a running sequence
   p_no_restart_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(flush_cpu_drv_o) |-> !$past(seq_busy));

endmodule

bind fis_flush_init_seq fis_flush_init_seq_chk #(.FLUSH_CYC(FLUSH_CYC)) u_chk (
   .clk_i          (clk_i),
   .rst_i          (rst_i),
   .mask_i         (mask_i),
   .init_i         (init_i),
   .flush_cpu_drv_o(flush_cpu_drv_o),
   .flush_hub_drv_o(flush_hub_drv_o),
   .init_drv_o     (init_drv_o),
   .trig           (trig),
   .seq_busy       (seq_busy)
);

// File: tb/fis_flush_init_seq_test.sv
`timescale 1ns/1ps
module fis_flush_init_seq_test;

   localparam int T1  = 8;
   localparam int TH  = 3;
   localparam int GAP = 1;
   localparam int SEQ = T1 + TH;

   logic clk = 1'b0;
   logic rst, mask, req, init;
   logic fc, fh, id;
   int   total = 0;
   int   bad   = 0;
   bit   done  = 0;

   always #5 clk = ~clk;

   fis_flush_init_seq #(
      .FLUSH_CYC(T1), .INIT_HALF_CYC(TH), .INIT_GAP_CYC(GAP), .SYNC_STAGES(0)
   ) uut (
      .clk_i(clk), .rst_i(rst), .mask_i(mask), .flush_req_i(req), .init_i(init),
      .flush_cpu_drv_o(fc), .flush_hub_drv_o(fh), .init_drv_o(id)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
      end
   endtask

   // one sweep point: idle with request high, then a falling request
   task automatic run_seq(input bit m, input bit ilvl, input bit tog, input bit retrig);
      logic cur_init;
      bit   inseq, ef, ei;
      @(negedge clk);
      mask = m; req = 1'b1; init = ilvl; cur_init = ilvl;
      @(posedge clk); #1;
      chk(fc, 1'b0, "R6 idle flush");
      chk(id, !ilvl, "R6 idle init");
      @(negedge clk);
      req = 1'b0;
      for (int i = 0; i <= SEQ + 1; i++) begin
         @(posedge clk); #1;
         inseq = m && (i < SEQ);
         ef = inseq && (i < T1);
         if (inseq)
            ei = ((i >= T1 - TH) && (i < SEQ)) || (!ilvl && (i < T1 - TH - GAP));
         else
            ei = !cur_init;
         if (m) begin
            chk(fc, ef, "R2 flush cpu");
            chk(fh, ef, "R2 flush hub");
            if (i >= T1 - TH && i < SEQ) chk(id, ei, "R3 init pulse");
            else if (!ilvl && i < T1 - TH) chk(id, ei, "R4 lead and gap");
            else if (i < SEQ) chk(id, ei, "R5 init ignored");
            else chk(id, ei, "R9 passthrough after end");
         end else begin
            chk(fc | fh, 1'b0, "R7 no flush");
            chk(id, ei, "R7 init follows");
         end
         if (tog && (i == 1 || i == 5)) begin
            init = ~init; cur_init = init;
         end
         if (retrig && i == 1) req = 1'b1;
         if (retrig && i == 3) req = 1'b0; // R8: falls mid-sequence, ignored
      end
   endtask

   initial begin
      rst = 1'b1; mask = 1'b1; req = 1'b1; init = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk(fc, 1'b0, "R1 reset flush cpu");
      chk(fh, 1'b0, "R1 reset flush hub");
      chk(id, 1'b0, "R1 reset init");
      // R1: request already low at the first post-reset edges
      @(negedge clk);
      rst = 1'b0; req = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #1;
         chk(fc, 1'b0, "R1 no trigger after reset");
         chk(id, 1'b0, "R1 init follows high input");
      end
      // R6: passthrough with request held high
      for (int v = 0; v < 4; v++) begin
         @(negedge clk);
         req = 1'b1; init = v[0]; mask = v[1];
         #1;
         chk(id, !init, "R6 passthrough");
         chk(fc, 1'b0, "R6 flush idle");
      end
      for (int k = 0; k < 16; k++)
         run_seq(k[0], k[1], k[2], k[3]);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule